// File: doc/BRIEF.md
# Three-Channel Sample Sequencer with Byte-Serial Output

The block steers one converter path across the red, green and blue outputs of a single pixel hold event. A rising edge on the pixel strobe, brought into the conversion-clock domain through a two-flop synchronizer, sends the channel selector back to red. The selector then steps to green and then blue on the following conversion-clock rising edges. It stays parked on blue, with the converter sample enable low, until the next strobe edge.

Each 16-bit result that comes back from the converter is matched with the channel tag that was selected when its sample was taken. It is then driven onto an 8-bit bus one clock later. The high byte is driven while the conversion clock is high and the low byte while it is low, with a byte-phase flag, a 2-bit channel tag and a valid flag beside the data. Results therefore trail the selector by a fixed number of cycles: the blue byte of one pixel can still be leaving while a later pixel is being selected.

Top module: `rgb_seq_top`

## Requirements
- R1: While rst_ni is low and until the first strobe edge takes effect, sel_o is 2'b10 (blue), smp_en_o is 0 and valid_o is 0.
- R2: If strobe_i is sampled low at conversion-clock rising edge m-1 and high at edge m, then in the cycle after edge m+2 sel_o is 2'b00 (red) and smp_en_o is 1.
- R3: With no new strobe edge, a red cycle is followed by a green cycle (sel_o 2'b01) and then a blue cycle (sel_o 2'b10), all with smp_en_o high.
- R4: After the blue cycle sel_o stays 2'b10 and smp_en_o stays 0 until the next strobe rising edge. A strobe held high for many cycles starts exactly one sequence.
- R5: A strobe rising edge that takes effect while green or blue is selected restarts the sequence at red, following the R2 timing.
- R6: result_i presented in cycle n+CONV_LAT is the conversion of the sample taken in cycle n. It is output in cycle n+CONV_LAT+1 with chan_o equal to the sel_o of cycle n and valid_o high.
- R7: During an output cycle, data_o carries result bits 15:8 with byte_hi_o=1 while clk_i is high, and result bits 7:0 with byte_hi_o=0 while clk_i is low.
- R8: valid_o is 0 in every output cycle whose matching cycle n had smp_en_o low. The value on result_i during such cycles has no effect on valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Pixel sample strobe, asynchronous to clk_i |
| result_i | input | 16 | Converter result, CONV_LAT cycles after its sample |
| sel_o | output | 2 | Channel select: 00 red, 01 green, 10 blue |
| smp_en_o | output | 1 | Converter sample enable for the selected channel |
| data_o | output | 8 | Byte-serial result data |
| byte_hi_o | output | 1 | 1 while the high byte is on data_o |
| chan_o | output | 2 | Channel tag of the result being output |
| valid_o | output | 1 | Output cycle carries a real result |

## Verification
A behavioural converter in the bench returns a channel- and pixel-dependent code. A cycle model derived from the requirements predicts the selector, the enable and both bytes in every cycle. Strobe periods are swept from two to six cycles. Two-cycle periods cut sequences off at green (R5), three-cycle periods give back-to-back pixels with overlapping output, and longer periods leave blue idle gaps where valid_o must stay low. A strobe held high for many cycles separates edge detection from level detection. The bench drives a poison value on result_i in unmatched cycles, which exposes any misalignment of the tag pipeline.

// File: rtl/rgb_seq_pkg.sv
`timescale 1ns/1ps
package rgb_seq_pkg;
  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;

  typedef struct packed {
    logic  vld;
    chan_e ch;
  } tag_t;
endpackage

// File: rtl/rgb_strobe_sync.sv
`timescale 1ns/1ps
module rgb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  // edge between last synchronizer flop and the history flop
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rgb_chan_seq.sv
`timescale 1ns/1ps
module rgb_chan_seq
  import rgb_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  output chan_e sel_o,
  output logic  act_o
);
  chan_e sel_q;
  logic  act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= CH_BLU;
      act_q <= 1'b0;
    end else if (restart_i) begin
      sel_q <= CH_RED;
      act_q <= 1'b1;
    end else begin
      unique case (sel_q)
        CH_RED:  sel_q <= CH_GRN;
        CH_GRN:  sel_q <= CH_BLU;
        default: begin
          sel_q <= CH_BLU;
          act_q <= 1'b0;
        end
      endcase
    end
  end

  assign sel_o = sel_q;
  assign act_o = act_q;
endmodule

// File: rtl/rgb_tag_pipe.sv
`timescale 1ns/1ps
module rgb_tag_pipe
  import rgb_seq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  tag_t tag_i,
  output tag_t tag_o
);
  tag_t stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stg
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= tag_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign tag_o = stg_q[DEPTH-1];
endmodule

// File: rtl/rgb_byte_ser.sv
`timescale 1ns/1ps
module rgb_byte_ser
  import rgb_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int RES_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tag_t              tag_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              byte_hi_o,
  output logic [1:0]        chan_o,
  output logic              valid_o
);
  logic [RES_W-1:0] word_q;
  tag_t             tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      tag_q  <= '0;
    end else begin
      word_q <= result_i;
      tag_q  <= tag_i;
    end
  end

  // high half of the clock carries the upper byte
  assign byte_hi_o = clk_i;
  assign data_o    = clk_i ? word_q[RES_W-1 -: BYTE_W] : word_q[BYTE_W-1:0];
  assign chan_o    = tag_q.ch;
  assign valid_o   = tag_q.vld;
endmodule

// File: rtl/rgb_seq_top.sv
`timescale 1ns/1ps
module rgb_seq_top
  import rgb_seq_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int CONV_LAT    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [1:0]        sel_o,
  output logic              smp_en_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              byte_hi_o,
  output logic [1:0]        chan_o,
  output logic              valid_o
);
  logic  rise;
  chan_e sel;
  logic  act;
  tag_t  tag_in, tag_al;

  rgb_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .strobe_i, .rise_o(rise)
  );

  rgb_chan_seq u_seq (
    .clk_i, .rst_ni, .restart_i(rise), .sel_o(sel), .act_o(act)
  );

  assign tag_in = '{vld: act, ch: sel};

  rgb_tag_pipe #(.DEPTH(CONV_LAT)) u_pipe (
    .clk_i, .rst_ni, .tag_i(tag_in), .tag_o(tag_al)
  );

  rgb_byte_ser #(.BYTE_W(BYTE_W)) u_ser (
    .clk_i, .rst_ni, .tag_i(tag_al), .result_i,
    .data_o, .byte_hi_o, .chan_o, .valid_o
  );

  assign sel_o    = sel;
  assign smp_en_o = act;
endmodule

// File: rtl/rgb_seq_chk.sv
`timescale 1ns/1ps
module rgb_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rise_i,
  input logic [1:0] sel_i,
  input logic       en_i,
  input logic [1:0] chan_i,
  input logic       valid_i
);
  a_r2_red_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (sel_i == 2'b00) && en_i);

  a_r3_red_to_grn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && sel_i == 2'b00) |=> (sel_i == 2'b01) && en_i);

  a_r3_grn_to_blu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && sel_i == 2'b01) |=> (sel_i == 2'b10) && en_i);

  a_r4_park_blue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && sel_i == 2'b10) |=> (sel_i == 2'b10) && !en_i);

  a_r3_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i != 2'b11);

  a_r6_tag_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> chan_i != 2'b11);
endmodule

bind rgb_seq_top rgb_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rise_i  (rise),
  .sel_i   (sel_o),
  .en_i    (smp_en_o),
  .chan_i  (chan_o),
  .valid_i (valid_o)
);

// File: tb/tb_rgb_seq_top.sv
`timescale 1ns/1ps
module tb_rgb_seq_top;
  localparam int L = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] result_i = 16'hDEAD;
  logic [1:0]  sel_o, chan_o;
  logic        smp_en_o, byte_hi_o, valid_o;
  logic [7:0]  data_o;

  rgb_seq_top dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit run = 0, done = 0;
  logic [7:0] cur_pix = 0;

  bit         str_h [64];
  logic [7:0] pix_h [64];
  bit         ev    [64];
  logic [1:0] ech   [64];
  logic [15:0] rv   [64];
  int k = 3;
  logic [7:0] snap = 0;

  function automatic logic [15:0] conv(logic [7:0] p, logic [1:0] c);
    return (16'(p) * 16'd257) ^ (16'(c) * 16'h1111 + 16'h0F0F);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      str_h[i] = 0; pix_h[i] = 0; ev[i] = 0; ech[i] = 0; rv[i] = 0;
    end
  end

  // cycle model and checks
  initial begin
    @(posedge run);
    forever begin
      @(posedge clk_i);
      cyc++;
      str_h[cyc & 63] = strobe_i;
      pix_h[cyc & 63] = cur_pix;
      if (cyc >= 3 && str_h[(cyc-2) & 63] && !str_h[(cyc-3) & 63]) begin
        k = 0; snap = pix_h[(cyc-2) & 63];
      end else if (k < 3) k++;
      #1;
      if (cyc > L && ev[(cyc-L) & 63]) result_i = rv[(cyc-L) & 63];
      else result_i = 16'hDEAD;
      #1;
      // R2 R3 R4 R5 selector and enable
      chk(sel_o == ((k == 3) ? 2'd2 : 2'(k)), "R3 sel", sel_o, (k == 3) ? 2 : k);
      chk(smp_en_o == (k < 3), "R4 smp_en", smp_en_o, k < 3);
      if (cyc > L + 1) begin
        automatic int j = (cyc - L - 1) & 63;
        chk(valid_o == ev[j], "R8 valid", valid_o, ev[j]);
        if (ev[j]) begin
          chk(chan_o == ech[j], "R6 chan", chan_o, ech[j]);
          chk(data_o == rv[j][15:8], "R7 hi byte", data_o, rv[j][15:8]);
          chk(byte_hi_o == 1'b1, "R7 phase hi", byte_hi_o, 1);
        end
      end else begin
        chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
      end
      @(negedge clk_i);
      ev[cyc & 63]  = (k < 3);
      ech[cyc & 63] = (k == 3) ? 2'd2 : 2'(k);
      rv[cyc & 63]  = conv(snap, (k == 3) ? 2'd2 : 2'(k));
      #2;
      if (cyc > L + 1) begin
        automatic int j = (cyc - L - 1) & 63;
        if (ev[j]) begin
          chk(data_o == rv[j][7:0], "R7 lo byte", data_o, rv[j][7:0]);
          chk(byte_hi_o == 1'b0, "R7 phase lo", byte_hi_o, 0);
          chk(chan_o == ech[j], "R6 chan lo", chan_o, ech[j]);
        end
      end
    end
  end

  task automatic pixel(logic [7:0] p, int per);
    @(negedge clk_i);
    strobe_i = 1'b1; cur_pix = p;
    @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (per - 2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(sel_o == 2'd2, "R1 sel", sel_o, 2);
    chk(smp_en_o == 1'b0, "R1 smp_en", smp_en_o, 0);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    rst_ni = 1'b1;
    run = 1'b1;
    repeat (6) @(negedge clk_i);
    // R2 R3 R5 R6 sweep of strobe periods, 2 forces restarts
    for (int per = 2; per <= 6; per++)
      for (int i = 0; i < 6; i++) pixel(8'(per * 41 + i * 29 + 3), per);
    repeat (10) @(negedge clk_i);
    // R4 long strobe: one sequence only
    strobe_i = 1'b1; cur_pix = 8'hA5;
    repeat (12) @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (10) @(negedge clk_i);
    for (int i = 0; i < 4; i++) pixel(8'(255 - i * 17), 3);
    repeat (12) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule